// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked one-shot timer. It raises its output Q for a programmed number of clock cycles when a gated trigger condition is seen. Two gate inputs, one active low and one active high, combine with an active-low clear to give three trigger paths. A trigger that arrives while a pulse is running restarts the count, so a stream of triggers stretches the pulse. Holding the clear low ends a pulse and blocks every trigger. The complementary output Q_n always shows the inverse of Q.

All inputs are taken as already synchronised to the clock and free of bounce. Each input is registered once. An edge is found by comparing that registered value with the value from the cycle before. A qualifying edge presented before a rising clock edge makes Q rise at the following rising edge. The pulse length is a 16-bit cycle count. It is registered together with the gate inputs, so the value present with the qualifying edge is the one used.

Top module: `gated_oneshot`

## Requirements
- R1: During reset and after it, Q is low and Q_n is high. Input levels present when reset is released never start a pulse, because a trigger needs two samples taken after reset.
- R2: A low-to-high change on gate_hi while gate_lo_n is low starts a pulse. Q rises at the second rising clock edge after the change is applied.
- R3: A high-to-low change on gate_lo_n while gate_hi is high starts a pulse, with the same latency as R2.
- R4: A low-to-high change on clr_n while gate_lo_n is low and gate_hi is high starts a pulse, with the same latency as R2.
- R5: After a trigger carrying length N (N > 0), Q stays high for exactly N clock cycles. N is the pulse_len value applied together with the qualifying edge.
- R6: A valid trigger during an active pulse reloads the count with its own N. Q then stays high for N more cycles from that trigger, so the total pulse is longer.
- R7: When clr_n is low, Q is low from the second rising edge after clr_n goes low and stays low, whatever the gates do.
- R8: A gate edge that would trigger while clr_n is low starts no pulse, then or later. Clear takes priority over triggering.
- R9: A trigger carrying N = 0 is ignored. It starts no pulse, and a running pulse ends on its old schedule.
- R10: Q_n is the exact complement of Q on every cycle. Both come from registers.
- R11: Steady gate levels alone never trigger. A low-to-high change on gate_hi while gate_lo_n is high starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_lo_n | input | 1 | Active-low gate; its falling edge can trigger |
| gate_hi | input | 1 | Active-high gate; its rising edge can trigger |
| clr_n | input | 1 | Active-low clear; its rising edge can trigger when both gates enable |
| pulse_len | input | 16 | Pulse length N in clock cycles, taken with the trigger |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of q |

## Verification
On every cycle the assertions check the reset state of the outputs and that an active clear forces Q low. They also check that an accepted trigger loads the count and raises Q, that a running count steps down by one, that Q never rises without an accepted trigger, and that no trigger is raised without a change in the sampled inputs. The bench scenarios are needed for the end-to-end facts: which gate combination starts a pulse on each of the three paths, the exact pulse length seen at the pins, how long a retriggered pulse lasts in total, that clear beats a coincident edge, and that a zero length leaves a running pulse untouched.

// File: rtl/gos_pkg.sv
package gos_pkg;

    typedef struct packed {
        logic lo_n;
        logic hi;
        logic clr_n;
    } gate_s;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_HI_RISE,
        SRC_LO_FALL,
        SRC_CLR_RISE
    } trig_src_e;

    localparam gate_s GATE_IDLE = '{lo_n: 1'b1, hi: 1'b0, clr_n: 1'b1};

    function automatic logic gates_enable(input gate_s g);
        return (~g.lo_n) & g.hi;
    endfunction

    function automatic trig_src_e find_source(input gate_s cur, input gate_s prv);
        trig_src_e src;
        src = SRC_NONE;
        if (cur.clr_n && !prv.clr_n && gates_enable(cur))
            src = SRC_CLR_RISE;
        else if (!cur.lo_n && prv.lo_n && cur.hi)
            src = SRC_LO_FALL;
        else if (cur.hi && !prv.hi && !cur.lo_n)
            src = SRC_HI_RISE;
        return src;
    endfunction

endpackage

// File: rtl/gos_sampler.sv
module gos_sampler
    import gos_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  gate_s            raw,
    input  logic [LEN_W-1:0] len_in,
    output trig_src_e        src,
    output logic             trig,
    output logic             clear_act,
    output logic [LEN_W-1:0] len_q
);

    gate_s cur_q;
    gate_s prv_q;
    logic  primed_q;
    logic  hist_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= GATE_IDLE;
            prv_q     <= GATE_IDLE;
            len_q     <= '0;
            primed_q  <= 1'b0;
            hist_ok_q <= 1'b0;
        end else begin
            cur_q     <= raw;
            prv_q     <= cur_q;
            len_q     <= len_in;
            primed_q  <= 1'b1;
            hist_ok_q <= primed_q;
        end
    end

    always_comb begin
        src       = hist_ok_q ? find_source(cur_q, prv_q) : SRC_NONE;
        trig      = (src != SRC_NONE);
        clear_act = ~cur_q.clr_n;
    end

    // A trigger always needs a change between the two stored samples (R11)
    assert_edge_only_R11: assert property (@(posedge clk) disable iff (rst)
        trig |-> (cur_q != prv_q));

endmodule

// File: rtl/gos_timer.sv
module gos_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             clear_act,
    input  logic [LEN_W-1:0] len,
    output logic             q,
    output logic             q_n
);

    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             q_q, q_d, qn_q;
    logic             accept;

    always_comb begin
        accept = trig && (len != '0);
        cnt_d  = cnt_q;
        q_d    = q_q;
        if (clear_act) begin
            q_d   = 1'b0;
            cnt_d = '0;
        end else if (accept) begin
            q_d   = 1'b1;
            cnt_d = len;
        end else if (q_q) begin
            if (cnt_q <= CNT_ONE) begin
                q_d   = 1'b0;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q   <= 1'b0;
            qn_q  <= 1'b1;
            cnt_q <= '0;
        end else begin
            q_q   <= q_d;
            qn_q  <= ~q_d;
            cnt_q <= cnt_d;
        end
    end

    assign q   = q_q;
    assign q_n = qn_q;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!q_q && qn_q));

    assert_clear_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
        clear_act |=> !q_q);

    assert_load_on_trigger_R5: assert property (@(posedge clk) disable iff (rst)
        (!clear_act && trig && len != '0) |=> (q_q && cnt_q == $past(len)));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
        (!clear_act && !trig && q_q && cnt_q > CNT_ONE)
            |=> (q_q && cnt_q == $past(cnt_q) - CNT_ONE));

    // Q may only rise through an accepted trigger; a zero length is not one (R9)
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!q_q && !(trig && len != '0)) |=> !q_q);

endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
    import gos_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_lo_n,
    input  logic             gate_hi,
    input  logic             clr_n,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             q,
    output logic             q_n
);

    gate_s            raw;
    trig_src_e        src;
    logic             trig;
    logic             clear_act;
    logic [LEN_W-1:0] len_s;

    always_comb begin
        raw.lo_n  = gate_lo_n;
        raw.hi    = gate_hi;
        raw.clr_n = clr_n;
    end

    gos_sampler #(.LEN_W(LEN_W)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .raw       (raw),
        .len_in    (pulse_len),
        .src       (src),
        .trig      (trig),
        .clear_act (clear_act),
        .len_q     (len_s)
    );

    gos_timer #(.LEN_W(LEN_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .clear_act (clear_act),
        .len       (len_s),
        .q         (q),
        .q_n       (q_n)
    );

    // Outputs stay complementary on every cycle (R10)
    assert_complement_R10: assert property (@(posedge clk) disable iff (rst)
        q_n == !q);

endmodule

// File: tb/gated_oneshot_bench.sv
module gated_oneshot_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             gate_lo_n;
    logic             gate_hi;
    logic             clr_n;
    logic [LEN_W-1:0] pulse_len;
    logic             q;
    logic             q_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic  qv;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_item;

    gated_oneshot #(.LEN_W(LEN_W)) u_gated_oneshot (
        .clk       (clk),
        .rst       (rst),
        .gate_lo_n (gate_lo_n),
        .gate_hi   (gate_hi),
        .clr_n     (clr_n),
        .pulse_len (pulse_len),
        .q         (q),
        .q_n       (q_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic expv, input string tag, input string what);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the Q value expected
    // just after the following rising edge.
    task automatic cyc(input logic a, input logic b, input logic c,
                       input int n, input logic expv, input string tag);
        exp_t item;
        @(negedge clk);
        gate_lo_n = a;
        gate_hi   = b;
        clr_n     = c;
        pulse_len = LEN_W'(n);
        item.qv   = expv;
        item.tag  = tag;
        exp_q.push_back(item);
    endtask

    task automatic hold(input logic a, input logic b, input logic c, input int n,
                        input logic expv, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) cyc(a, b, c, n, expv, tag);
    endtask

    // Monitor: pops one expectation per rising edge and compares
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                mon_item = exp_q.pop_front();
                check(q, mon_item.qv, mon_item.tag, "q");
                check(q_n, ~mon_item.qv, "R10", "q_n");
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        gate_lo_n = 1'b0;
        gate_hi   = 1'b1;
        clr_n     = 1'b1;
        pulse_len = LEN_W'(4);
        repeat (3) @(negedge clk);
        check(q, 1'b0, "R1", "q in reset");
        check(q_n, 1'b1, "R1", "q_n in reset");
        rst = 1'b0;

        // R1: enabling levels held across reset release do not trigger
        hold(0, 1, 1, 4, 0, 4, "R1");
        // R11: return to idle, no trigger
        hold(1, 0, 1, 4, 0, 2, "R11");

        // R2: gate_hi rises with gate_lo_n low, N = 4
        cyc(0, 0, 1, 4, 0, "R2");
        cyc(0, 1, 1, 4, 0, "R2");
        hold(0, 1, 1, 4, 1, 4, "R5");
        hold(0, 1, 1, 4, 0, 2, "R5");
        hold(1, 0, 1, 4, 0, 2, "R11");

        // R11 then R3: gate_hi rises with gate_lo_n high (ignored), then gate_lo_n falls
        cyc(1, 1, 1, 3, 0, "R11");
        cyc(0, 1, 1, 3, 0, "R11");
        hold(0, 1, 1, 3, 1, 3, "R3");
        hold(0, 1, 1, 3, 0, 2, "R3");
        hold(1, 0, 1, 3, 0, 2, "R11");

        // R8: gate edges while clear is low, then R4: clear release triggers
        cyc(1, 0, 0, 5, 0, "R8");
        cyc(0, 1, 0, 5, 0, "R8");
        cyc(0, 1, 0, 5, 0, "R8");
        cyc(0, 1, 1, 5, 0, "R8");
        hold(0, 1, 1, 5, 1, 5, "R4");
        hold(0, 1, 1, 5, 0, 2, "R4");
        hold(1, 0, 1, 5, 0, 2, "R11");

        // R6: retrigger with a new length, total 3 + 6 cycles high
        cyc(0, 0, 1, 4, 0, "R6");
        cyc(0, 1, 1, 4, 0, "R6");
        cyc(0, 1, 1, 4, 1, "R6");
        cyc(0, 0, 1, 4, 1, "R6");
        cyc(0, 1, 1, 6, 1, "R6");
        hold(0, 1, 1, 6, 1, 6, "R6");
        hold(0, 1, 1, 6, 0, 2, "R6");
        hold(1, 0, 1, 6, 0, 2, "R11");

        // R9: zero length trigger from idle does nothing
        cyc(0, 0, 1, 0, 0, "R9");
        cyc(0, 1, 1, 0, 0, "R9");
        hold(0, 1, 1, 0, 0, 3, "R9");
        // R9: zero length retrigger does not change a running pulse of 3
        cyc(0, 0, 1, 3, 0, "R9");
        cyc(0, 1, 1, 3, 0, "R9");
        cyc(0, 1, 1, 3, 1, "R9");
        cyc(0, 0, 1, 3, 1, "R9");
        cyc(0, 1, 1, 0, 1, "R9");
        hold(0, 1, 1, 0, 0, 3, "R9");
        hold(1, 0, 1, 0, 0, 2, "R11");

        // R7: clear cuts a pulse of 8 short and holds Q low against gate edges
        cyc(0, 0, 1, 8, 0, "R7");
        cyc(0, 1, 1, 8, 0, "R7");
        cyc(0, 1, 1, 8, 1, "R7");
        cyc(0, 1, 0, 8, 1, "R7");
        cyc(0, 0, 0, 8, 0, "R7");
        cyc(0, 1, 0, 8, 0, "R7");
        cyc(0, 1, 0, 8, 0, "R7");
        cyc(1, 1, 1, 8, 0, "R7");
        cyc(1, 0, 1, 8, 0, "R7");
        hold(1, 0, 1, 8, 0, 3, "R7");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule